// File: doc/BRIEF.md
# Virtual-Channel Allocation Output Arbiter with Default-Winner Substitution

This block is the second-stage arbiter of a router's virtual-channel allocator, one instance per downstream virtual channel. It sees twenty candidate requests, four virtual channels from each of five input ports. In normal operation these come from the per-port first-stage arbiters. It grants at most one of them in the same cycle, with round-robin fairness.

Each input port has a sticky fault flag. The flag is raised once every first-stage arbiter of that port is known to be broken. While the flag is up, the port's four request lines are ignored. The arbiter substitutes a single request built from a per-port default-winner VC pointer and a per-VC "routed and waiting for an output VC" status line. The pointer moves on after each grant to that port, so every waiting VC behind a dead first stage is served in turn. The substitution is combinational and costs no cycle. Three invariance flags watch the grant vector against the effective request vector.

Top module: `vadw_va_arbiter`

## Requirements
- R1: After reset, all fault flags are clear, every default-winner pointer is VC 0 and the round-robin search starts at index 0. With all requests asserted in the first cycle, the grant is bit 0. With no requests, the grant is zero.
- R2: Request and grant bit index is port*4 + vc. The grant is combinational from the current cycle's inputs and has at most one bit set. A granted bit always carries an effective request.
- R3: Whenever any effective request is present, exactly one grant is issued in that cycle.
- R4: The search starts at the pointer and wraps through index 19 back to 0. After a grant at index g, the pointer becomes (g+1) mod 20.
- R5: A high bit p of fault_set_i sets port p's fault flag from the next cycle onward. The flag stays set until reset, whatever fault_set_i does later.
- R6: For a faulty port, its req_i bits have no effect. Its only effective request is the VC named by its default-winner pointer, and only when that VC's vc_wait_i bit is high.
- R7: When a faulty port is granted, its pointer moves to the first VC at cyclic offset 1, 2, 3 and then 0 from the current one whose vc_wait_i bit is high. If none is waiting, it moves to (current+1) mod 4.
- R8: When a faulty port is not granted and the VC under its pointer is not waiting, the pointer moves to the first waiting VC at offset 1, 2 or 3. If none is waiting, it holds. If the VC under the pointer is waiting, it holds.
- R9: err_o bit 0 flags a grant without an effective request, bit 1 flags requests with no grant, and bit 2 flags more than one grant bit. All three stay low in correct operation.
- R10: For a port without a fault flag, vc_wait_i has no effect. Its req_i bits are used directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 20 | First-stage requests, index port*4+vc |
| vc_wait_i | input | 20 | VC routed and awaiting an output VC, index port*4+vc |
| fault_set_i | input | 5 | Per-port pulse marking all first-stage arbiters dead |
| gnt_o | output | 20 | One-hot grant, index port*4+vc |
| err_o | output | 3 | Invariance flags: spurious, lost, multiple grant |

## Verification
The embedded assertions cover properties that hold on every cycle:
- the grant is one-hot or zero;
- a granted healthy port was requesting, and a granted faulty VC was waiting;
- any effective request yields a grant;
- fault flags never clear;
- the pointer lands just past the winner;
- a default-winner pointer holds while its VC waits ungranted.

Properties that span several cycles can only be shown by the bench's scenarios. These are the rotation order of the default winner across successive grants, the skip past idle VCs, and the fairness of the wrap-around search under mixed traffic. The bench exposes them by comparing every grant against a behavioural model.

// File: rtl/vadw_pkg.sv
package vadw_pkg;
  localparam int unsigned ERR_SPUR  = 0;
  localparam int unsigned ERR_LOST  = 1;
  localparam int unsigned ERR_MULTI = 2;
  localparam int unsigned ERR_W     = 3;
endpackage

// File: rtl/vadw_rr_arb.sv
module vadw_rr_arb #(
  parameter int unsigned N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q, ptr_d, win;
  logic          hit;

  always_comb begin
    gnt_o = '0;
    hit   = 1'b0;
    win   = '0;
    for (int off = 0; off < int'(N); off++) begin
      logic [PW-1:0] cand;
      cand = PW'((int'(ptr_q) + off) % int'(N));
      if (!hit && req_i[cand]) begin
        hit = 1'b1;
        win = cand;
      end
    end
    if (hit) gnt_o[win] = 1'b1;
    ptr_d = ptr_q;
    if (hit) ptr_d = PW'((int'(win) + 1) % int'(N));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  // R4: search restarts just past the last winner
  p_ptr_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (int'(ptr_q) == (int'($past(win)) + 1) % int'(N)));
endmodule

// File: rtl/vadw_dw_unit.sv
module vadw_dw_unit #(
  parameter int unsigned V = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         faulty_i,
  input  logic         granted_i,
  input  logic [V-1:0] req_i,
  input  logic [V-1:0] wait_i,
  output logic [V-1:0] eff_req_o
);
  localparam int unsigned VW = (V > 1) ? $clog2(V) : 1;

  logic [VW-1:0] dw_q, dw_d, nxt;
  logic          found;
  logic [V-1:0]  sel;

  // first waiting VC at offsets 1..V (offset V is the current one)
  always_comb begin
    found = 1'b0;
    nxt   = dw_q;
    for (int k = 1; k <= int'(V); k++) begin
      logic [VW-1:0] cand;
      cand = VW'((int'(dw_q) + k) % int'(V));
      if (!found && wait_i[cand]) begin
        found = 1'b1;
        nxt   = cand;
      end
    end
  end

  always_comb begin
    dw_d = dw_q;
    if (faulty_i) begin
      if (granted_i)
        dw_d = found ? nxt : VW'((int'(dw_q) + 1) % int'(V));
      else if (!wait_i[dw_q] && found)
        dw_d = nxt;
    end
  end

  always_comb begin
    sel       = '0;
    sel[dw_q] = wait_i[dw_q];
    eff_req_o = faulty_i ? sel : req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dw_q <= '0;
    else         dw_q <= dw_d;
  end

  // R6: a faulty port presents at most one request
  p_single_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    faulty_i |-> $onehot0(eff_req_o));
  // R8: a waiting default winner is not abandoned before it is served
  p_dw_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (faulty_i && !granted_i && wait_i[dw_q]) |=> $stable(dw_q));
endmodule

// File: rtl/vadw_gnt_check.sv
module vadw_gnt_check
  import vadw_pkg::*;
#(
  parameter int unsigned N = 20
) (
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     gnt_i,
  output logic [ERR_W-1:0] err_o
);
  logic [$clog2(N+1)-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < int'(N); i++) ones = ones + {{($clog2(N+1)-1){1'b0}}, gnt_i[i]};
    err_o            = '0;
    err_o[ERR_SPUR]  = |(gnt_i & ~req_i);
    err_o[ERR_LOST]  = (|req_i) && !(|gnt_i);
    err_o[ERR_MULTI] = ones > 1;
  end
endmodule

// File: rtl/vadw_va_arbiter.sv
module vadw_va_arbiter
  import vadw_pkg::*;
#(
  parameter int unsigned PORTS = 5,
  parameter int unsigned VCS   = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [PORTS*VCS-1:0]   req_i,
  input  logic [PORTS*VCS-1:0]   vc_wait_i,
  input  logic [PORTS-1:0]       fault_set_i,
  output logic [PORTS*VCS-1:0]   gnt_o,
  output logic [ERR_W-1:0]       err_o
);
  localparam int unsigned N = PORTS * VCS;

  logic [PORTS-1:0] fault_q;
  logic [N-1:0]     eff_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= '0;
    else         fault_q <= fault_q | fault_set_i;
  end

  for (genvar p = 0; p < int'(PORTS); p++) begin : g_port
    vadw_dw_unit #(.V(VCS)) u_dw (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .faulty_i  (fault_q[p]),
      .granted_i (|gnt_o[p*VCS +: VCS]),
      .req_i     (req_i[p*VCS +: VCS]),
      .wait_i    (vc_wait_i[p*VCS +: VCS]),
      .eff_req_o (eff_req[p*VCS +: VCS])
    );

    // R10: a healthy port is granted only on its own request line
    p_healthy_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fault_q[p] && |gnt_o[p*VCS +: VCS]) |-> |(gnt_o[p*VCS +: VCS] & req_i[p*VCS +: VCS]));
    // R6: a faulty port is granted only on a waiting VC
    p_faulty_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_q[p] |-> ((gnt_o[p*VCS +: VCS] & ~vc_wait_i[p*VCS +: VCS]) == '0));
  end

  vadw_rr_arb #(.N(N)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (eff_req),
    .gnt_o  (gnt_o)
  );

  vadw_gnt_check #(.N(N)) u_chk (
    .req_i (eff_req),
    .gnt_i (gnt_o),
    .err_o (err_o)
  );

  p_onehot_gnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_work_cons_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eff_req) |-> (|gnt_o));
  p_fault_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
  p_flags_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == '0);
endmodule

// File: tb/sim_vadw_va_arbiter.sv
module sim_vadw_va_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int P = 5;
  localparam int V = 4;
  localparam int N = P * V;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] vc_wait_i = '0;
  logic [P-1:0] fault_set_i = '0;
  logic [N-1:0] gnt_o;
  logic [2:0]   err_o;

  int checks = 0;
  int errors = 0;
  int ptrm = 0;
  int dwm[P];
  bit fm[P];

  always #(CLK_PERIOD/2) clk = ~clk;

  vadw_va_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .vc_wait_i(vc_wait_i),
    .fault_set_i(fault_set_i), .gnt_o(gnt_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive, compare against model, advance model
  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] wt, input logic [P-1:0] fs, input string tag);
    logic [N-1:0] eff, exp;
    int g;
    @(negedge clk);
    req_i = rq; vc_wait_i = wt; fault_set_i = fs;
    #1;
    eff = '0;
    for (int p = 0; p < P; p++)
      for (int v = 0; v < V; v++)
        if (fm[p]) eff[p*V+v] = (v == dwm[p]) && wt[p*V+v];
        else       eff[p*V+v] = rq[p*V+v];
    exp = '0; g = -1;
    for (int o = 0; o < N; o++) begin
      int c = (ptrm + o) % N;
      if (g < 0 && eff[c]) g = c;
    end
    if (g >= 0) exp[g] = 1'b1;
    chk(gnt_o === exp, tag, 32'(gnt_o), 32'(exp));
    chk(err_o === 3'b000, "R9", 32'(err_o), 32'h0);
    chk($countones(gnt_o) <= 1, "R2", 32'(gnt_o), 32'(exp));
    chk((|gnt_o) == (|eff), "R3", 32'(|gnt_o), 32'(|eff));
    if (g >= 0) ptrm = (g + 1) % N;
    for (int p = 0; p < P; p++) begin
      if (fm[p]) begin
        int nx = -1;
        for (int k = 1; k <= V; k++) begin
          int c = (dwm[p] + k) % V;
          if (nx < 0 && wt[p*V+c]) nx = c;
        end
        if (g >= 0 && g / V == p) dwm[p] = (nx >= 0) ? nx : (dwm[p] + 1) % V;
        else if (!wt[p*V+dwm[p]] && nx >= 0) dwm[p] = nx;
      end
      if (fs[p]) fm[p] = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < P; p++) begin dwm[p] = 0; fm[p] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(gnt_o === '0, "R1", 32'(gnt_o), 32'h0);
    chk(err_o === 3'b000, "R1", 32'(err_o), 32'h0);
    @(negedge clk); rst_ni = 1'b1;
    step('1, '0, '0, "R1");
    // full load: strict rotation through all 20 indices
    for (int i = 0; i < 25; i++) step('1, '0, '0, "R4");
    // healthy traffic with noise on vc_wait_i
    for (int i = 0; i < 200; i++) step(N'($urandom), N'($urandom), '0, "R10");
    // port 1 loses its first stage
    step('0, '0, 5'b00010, "R5");
    // requests only from dead port: ignored
    for (int i = 0; i < 4; i++) step(20'h000F0, '0, '0, "R6");
    // all VCs of port 1 waiting: served 0,1,2,3 in turn
    for (int i = 0; i < 8; i++) step('0, 20'h000F0, '0, "R7");
    // pointer skips to the only waiting VC
    step('0, 20'h00040, '0, "R8");
    step('0, 20'h00040, '0, "R8");
    step('0, 20'h00000, '0, "R8");
    // mixed traffic with one dead port
    for (int i = 0; i < 300; i++) step(N'($urandom), N'($urandom), '0, "R6");
    // more ports die, pulses come and go
    for (int i = 0; i < 300; i++) step(N'($urandom), N'($urandom), P'($urandom) & 5'b10101, "R5");
    for (int i = 0; i < 200; i++) step(N'($urandom), N'($urandom), '1, "R7");
    for (int i = 0; i < 100; i++) step('0, N'($urandom) & N'($urandom), '0, "R8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule